// File: doc/BRIEF.md
# Sustained DC Offset Fault Detector

The block watches several amplifier output channels for a DC offset that lasts. Each channel delivers one signed, already digitised offset sample per clock. The block takes the magnitude of each sample and compares it with a programmable level. Only an excess that holds for a programmable number of consecutive cycles is recorded as a fault. Detection runs only while the run input marks normal operation.

Each channel keeps its own sticky fault flag, which is cleared by a write-one-to-clear pulse. When the shutdown enable is set, a detection also raises a shutdown request for that channel alone, and the other channels keep playing. An active-low summary line, modelled on an open-drain fault pin, goes low while any channel holds a fault. The level, the hold time and the shutdown enable arrive as plain register-style inputs.

Top module: `dc_offset_guard`

## Requirements
- R1: After reset all fault flags and shutdown requests are 0 and fault_n_o is 1.
- R2: The compared quantity is the absolute value of the two's-complement sample. A channel qualifies in a cycle when that magnitude is greater than or equal to level_i, so a negative offset behaves exactly like a positive one of the same size, including the most negative code.
- R3: A fault flag is set after the clock edge that ends hold_time_i consecutive qualifying cycles, and not one edge sooner. A hold_time_i of 0 behaves like 1.
- R4: A cycle in which the magnitude is below level_i restarts that channel's count, so the full hold time is needed again.
- R5: While run_i is 0 the counts are held at zero and no new fault is set; flags that are already set keep their value.
- R6: A fault flag stays set until a cycle with the matching bit of clear_i at 1. Bits of clear_i for other channels do not affect it.
- R7: A clear applied while the channel still qualifies with its hold time met leaves the flag set.
- R8: With shdn_en_i at 0 no shutdown request is raised, even when a fault is detected.
- R9: With shdn_en_i at 1 a detection raises the shutdown request of the triggered channel only. The flags and requests of the other channels stay unchanged.
- R10: A shutdown request is released in the same cycle that its fault flag clears, which can happen only once the offset is gone.
- R11: fault_n_o is 0 whenever any fault flag is set and 1 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| run_i | input | 1 | Normal operation; detection enabled |
| sample_i | input | NUM_CH*SAMPLE_W | Signed offset samples, channel c at bits [c*SAMPLE_W +: SAMPLE_W] |
| level_i | input | SAMPLE_W | Unsigned detection level |
| hold_time_i | input | TIME_W | Required consecutive qualifying cycles |
| shdn_en_i | input | 1 | Shutdown on detection enable |
| clear_i | input | NUM_CH | Write-one-to-clear pulses for the fault flags |
| fault_o | output | NUM_CH | Sticky per-channel fault flags |
| shdn_o | output | NUM_CH | Per-channel shutdown requests |
| fault_n_o | output | 1 | Shared fault indication, active low |

## Verification
The main function is driven with a steady positive offset above the level, a negative offset of the same size, an offset exactly at the level, one just below it, and the most negative code. Together these show whether the magnitude is formed correctly and whether the compare includes equality. A run that breaks off one cycle before the hold time expires, and a qualifying stretch interrupted by a single low sample, show whether the count is off by one and whether it restarts. Clears and shutdown tests on one channel while a neighbour sits idle or faulted show that each channel acts alone. A clear applied while the offset persists shows that the clear does not override a live detection.

// File: rtl/dc_guard_pkg.sv
package dc_guard_pkg;
  typedef struct packed {
    logic fault;
    logic shdn;
  } chan_stat_t;
endpackage

// File: rtl/dc_mag_cmp.sv
module dc_mag_cmp #(
  parameter int SAMPLE_W = 16
) (
  input  logic [SAMPLE_W-1:0] sample_i,
  input  logic [SAMPLE_W-1:0] level_i,
  output logic                over_o
);
  logic [SAMPLE_W-1:0] mag;

  // two's complement negate; most negative code maps to 2^(W-1) unsigned
  always_comb begin
    mag    = sample_i[SAMPLE_W-1] ? (~sample_i + 1'b1) : sample_i;
    over_o = (mag >= level_i);
  end
endmodule

// File: rtl/dc_persist_cnt.sv
module dc_persist_cnt #(
  parameter int TIME_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              over_i,
  input  logic [TIME_W-1:0] hold_i,
  output logic              hit_o
);
  localparam logic [TIME_W-1:0] CNT_MAX = '1;

  logic [TIME_W-1:0] cnt_q;
  logic [TIME_W:0]   cnt_nxt;
  logic              qual;

  assign qual    = run_i & over_i;
  assign cnt_nxt = {1'b0, cnt_q} + 1'b1;
  // hold of 0 acts as 1: first qualifying edge hits
  assign hit_o   = qual & (cnt_nxt >= {1'b0, hold_i});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (!qual)         cnt_q <= '0;
    else if (cnt_q != CNT_MAX) cnt_q <= cnt_nxt[TIME_W-1:0];
  end

  AST_CNT_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i || !over_i) |=> (cnt_q == '0)); // R4
  AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (qual && cnt_q != CNT_MAX) |=> (cnt_q == $past(cnt_q) + 1'b1)); // R3
  AST_NO_HIT_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |-> !hit_o); // R5
endmodule

// File: rtl/dc_fault_latch.sv
module dc_fault_latch
  import dc_guard_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       hit_i,
  input  logic       clr_i,
  input  logic       shdn_en_i,
  output chan_stat_t stat_o
);
  logic fault_q, shdn_q, fault_d;

  // live detection wins over clear
  assign fault_d = hit_i | (fault_q & ~clr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fault_q <= 1'b0;
      shdn_q  <= 1'b0;
    end else begin
      fault_q <= fault_d;
      shdn_q  <= fault_d & (shdn_q | (hit_i & shdn_en_i));
    end
  end

  assign stat_o.fault = fault_q;
  assign stat_o.shdn  = shdn_q;

  AST_SHDN_NEEDS_FAULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shdn_q |-> fault_q); // R10
  AST_FAULT_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_q && !clr_i) |=> fault_q); // R6
  AST_NO_SHDN_DISABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!shdn_en_i && !shdn_q) |=> !shdn_q); // R8
  AST_CLR_LIVE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && hit_i) |=> fault_q); // R7
  AST_RISE_FROM_HIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fault_q) |-> $past(hit_i)); // R3
endmodule

// File: rtl/dc_offset_guard.sv
module dc_offset_guard
  import dc_guard_pkg::*;
#(
  parameter int NUM_CH   = 4,
  parameter int SAMPLE_W = 16,
  parameter int TIME_W   = 16
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       run_i,
  input  logic [NUM_CH*SAMPLE_W-1:0] sample_i,
  input  logic [SAMPLE_W-1:0]        level_i,
  input  logic [TIME_W-1:0]          hold_time_i,
  input  logic                       shdn_en_i,
  input  logic [NUM_CH-1:0]          clear_i,
  output logic [NUM_CH-1:0]          fault_o,
  output logic [NUM_CH-1:0]          shdn_o,
  output logic                       fault_n_o
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic       over, hit;
    chan_stat_t stat;

    dc_mag_cmp #(.SAMPLE_W(SAMPLE_W)) mag_i (
      .sample_i (sample_i[c*SAMPLE_W +: SAMPLE_W]),
      .level_i  (level_i),
      .over_o   (over)
    );

    dc_persist_cnt #(.TIME_W(TIME_W)) cnt_i (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .run_i  (run_i),
      .over_i (over),
      .hold_i (hold_time_i),
      .hit_o  (hit)
    );

    dc_fault_latch latch_i (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .hit_i     (hit),
      .clr_i     (clear_i[c]),
      .shdn_en_i (shdn_en_i),
      .stat_o    (stat)
    );

    assign fault_o[c] = stat.fault;
    assign shdn_o[c]  = stat.shdn;
  end

  assign fault_n_o = ~|fault_o;

  AST_LINE_LOW_ON_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(|fault_o) |-> !fault_n_o); // R11
endmodule

// File: tb/dc_offset_guard_tb_top.sv
module dc_offset_guard_tb_top;
  localparam int NC = 4;
  localparam int SW = 16;
  localparam int TW = 16;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             run;
  logic [NC*SW-1:0] sample;
  logic [SW-1:0]    level;
  logic [TW-1:0]    hold;
  logic             shdn_en;
  logic [NC-1:0]    clear;
  logic [NC-1:0]    fault, shdn;
  logic             fault_n;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  dc_offset_guard #(.NUM_CH(NC), .SAMPLE_W(SW), .TIME_W(TW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .run_i(run), .sample_i(sample),
    .level_i(level), .hold_time_i(hold), .shdn_en_i(shdn_en),
    .clear_i(clear), .fault_o(fault), .shdn_o(shdn), .fault_n_o(fault_n)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_ch(input int c, input int v);
    sample[c*SW +: SW] = v[SW-1:0];
  endtask

  task automatic do_reset(input int lvl, input int hld, input bit sen);
    rst_n = 1'b0; run = 1'b1; sample = '0; clear = '0;
    level = lvl[SW-1:0]; hold = hld[TW-1:0]; shdn_en = sen;
    tick(2);
    rst_n = 1'b1;
    tick(1);
  endtask

  task automatic t_reset;
    do_reset(100, 5, 1'b1);
    chk("R1 fault", {28'd0, fault}, 32'h0);
    chk("R1 shdn", {28'd0, shdn}, 32'h0);
    chk("R1 fault_n", {31'd0, fault_n}, 32'h1);
  endtask

  task automatic t_timing;
    do_reset(100, 5, 1'b0);
    set_ch(0, 150);
    tick(4);
    chk("R3 before expiry", {28'd0, fault}, 32'h0);
    chk("R11 idle line", {31'd0, fault_n}, 32'h1);
    tick(1);
    chk("R3 at expiry", {28'd0, fault}, 32'h1);
    chk("R11 line low", {31'd0, fault_n}, 32'h0);
    chk("R8 no shdn", {28'd0, shdn}, 32'h0);
    do_reset(100, 0, 1'b0);
    set_ch(2, 120);
    tick(1);
    chk("R3 hold zero", {28'd0, fault}, 32'h4);
  endtask

  task automatic t_magnitude;
    do_reset(100, 3, 1'b0);
    set_ch(1, -150); set_ch(2, -99); set_ch(3, 100);
    tick(3);
    chk("R2 neg/below/equal", {28'd0, fault}, 32'ha);
    do_reset(32767, 2, 1'b0);
    set_ch(0, -32768); set_ch(1, 32766);
    tick(2);
    chk("R2 most negative", {28'd0, fault}, 32'h1);
  endtask

  task automatic t_restart;
    do_reset(100, 5, 1'b0);
    set_ch(0, 200);
    tick(3);
    set_ch(0, 50);
    tick(1);
    set_ch(0, 200);
    tick(4);
    chk("R4 restarted", {28'd0, fault}, 32'h0);
    tick(1);
    chk("R4 full hold", {28'd0, fault}, 32'h1);
  endtask

  task automatic t_run_gate;
    do_reset(100, 3, 1'b0);
    run = 1'b0;
    set_ch(1, 300);
    tick(10);
    chk("R5 idle no fault", {28'd0, fault}, 32'h0);
    run = 1'b1;
    tick(2);
    chk("R5 count from zero", {28'd0, fault}, 32'h0);
    tick(1);
    chk("R5 fault after run", {28'd0, fault}, 32'h2);
    run = 1'b0;
    set_ch(1, 0);
    tick(3);
    chk("R5 flag kept", {28'd0, fault}, 32'h2);
  endtask

  task automatic t_clear;
    do_reset(100, 2, 1'b0);
    set_ch(0, 200); set_ch(3, -200);
    tick(2);
    set_ch(0, 0); set_ch(3, 0);
    tick(5);
    chk("R6 sticky", {28'd0, fault}, 32'h9);
    clear = 4'b0110;
    tick(1);
    clear = '0;
    chk("R6 other bits", {28'd0, fault}, 32'h9);
    clear = 4'b0001;
    tick(1);
    clear = '0;
    chk("R6 cleared ch0", {28'd0, fault}, 32'h8);
    clear = 4'b1000;
    tick(1);
    clear = '0;
    chk("R6 all clear", {28'd0, fault}, 32'h0);
    chk("R11 released", {31'd0, fault_n}, 32'h1);
    set_ch(2, 500);
    tick(2);
    clear = 4'b0100;
    tick(1);
    clear = '0;
    chk("R7 live clear", {28'd0, fault}, 32'h4);
  endtask

  task automatic t_shutdown;
    do_reset(100, 3, 1'b1);
    set_ch(1, 400);
    tick(3);
    chk("R9 only ch1 fault", {28'd0, fault}, 32'h2);
    chk("R9 only ch1 shdn", {28'd0, shdn}, 32'h2);
    clear = 4'b0010;
    tick(1);
    clear = '0;
    chk("R10 held while offset", {28'd0, shdn}, 32'h2);
    set_ch(1, 0);
    tick(1);
    clear = 4'b0010;
    tick(1);
    clear = '0;
    chk("R10 shdn released", {28'd0, shdn}, 32'h0);
    chk("R10 fault released", {28'd0, fault}, 32'h0);
    shdn_en = 1'b0;
    set_ch(3, -400);
    tick(3);
    chk("R8 fault no shdn", {28'd0, shdn}, 32'h0);
    chk("R8 fault set", {28'd0, fault}, 32'h8);
  endtask

  initial begin
    rst_n = 1'b0; run = 1'b0; sample = '0; level = '0;
    hold = '0; shdn_en = 1'b0; clear = '0;
    t_reset();
    t_timing();
    t_magnitude();
    t_restart();
    t_run_gate();
    t_clear();
    t_shutdown();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule